// File: doc/BRIEF.md
# Priority Address Decoder with Timed Configuration Register

This block sits on a 16-bit CPU address bus and turns each read or write strobe into a chip select for one of three on-chip resources: a register file, a static RAM and a ROM. Each resource has a window set by a base address and a byte size, both fixed by parameters. The windows may overlap. Where they overlap, a fixed hardware priority decides which resource is selected: the register file first, then RAM, then ROM. Only that one select is asserted, for reads and for writes alike.

The block also holds an 8-bit system configuration register at byte offset 0x3F of the register-file window. In normal mode software gets a single write to it, and only within the first 64 bus cycles after reset. In special mode it may be rewritten at any time. Bit 1 of the register enables the ROM. When that bit is 0, addresses that only the ROM claims select nothing.

Top module: `addr_prio_decoder`

## Requirements
- R1: An address inside the register-file window asserts `sel_reg` only, even when the RAM or ROM window also covers it.
- R2: An address inside the RAM window but outside the register-file window asserts `sel_ram` only, even when the ROM window also covers it.
- R3: At most one select is high in any cycle, and no select is high unless `bus_rd` or `bus_wr` is high.
- R4: A strobed address outside every window asserts no select. A read of such an address returns `rd_data` = 0xFF.
- R5: Configuration bit 1 is the ROM enable. While it is 0, an address claimed only by the ROM asserts no select and reads as 0xFF.
- R6: The configuration register sits at register-file base + 0x3F. A read there returns its contents on `rd_data`, and its contents are always visible on `cfg_bits`.
- R7: In normal mode (`special_mode` = 0), the first write to the configuration register is stored if it happens on bus cycles 0 to 63 after reset. Cycle 0 is the first clock edge with `rst_n` high.
- R8: In normal mode, after one write has been accepted, every later write to the configuration register is ignored.
- R9: In normal mode, a write on bus cycle 64 or later is ignored, even if no write has been accepted before.
- R10: In special mode (`special_mode` = 1), every write to the configuration register is stored, at any cycle, any number of times.
- R11: Reset (synchronous, `rst_n` low) loads the configuration register with 0x02, so the ROM is enabled. It also restarts the cycle count and clears the write-once state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; one rising edge per bus cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | CPU address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| special_mode | input | 1 | 1 = special mode, 0 = normal mode |
| sel_reg | output | 1 | Register-file select |
| sel_ram | output | 1 | RAM select |
| sel_rom | output | 1 | ROM select |
| cfg_bits | output | 8 | Current configuration register contents |
| rd_data | output | 8 | Decoder read data: configuration value, or 0xFF when unmapped or not reading, else 0x00 |

## Verification
The bound assertions watch every cycle for the following: select exclusivity and strobe gating, the winner of each overlap at the current address, ROM suppression while the enable bit is clear, the 0xFF read of unmapped space, the frozen register once the normal-mode window has closed, and the storing of every special-mode write. The directed scenarios are the only place that shows the exact cycle-63/cycle-64 boundary, the write-once rule inside the open window, the reset value, and decoding under a second, deliberately overlapping window placement.

// File: rtl/apd_pkg.sv
// Package: shared constants and the resource index used by the decoder.
// Assumes the register-file window is at least 64 bytes so the config
// offset lies inside it.
package apd_pkg;
    localparam int unsigned CFG_OFFSET = 63;   // byte offset of config reg
    localparam int unsigned ROM_EN_BIT = 1;    // config bit enabling the ROM
    localparam int unsigned NUM_RES    = 3;    // resources, index = priority

    typedef enum int unsigned {
        RES_REG = 0,
        RES_RAM = 1,
        RES_ROM = 2
    } res_idx_e;
endpackage

// File: rtl/apd_window.sv
// Module: apd_window
// Flags whether an address lies inside [BASE, BASE+SIZE).
// Assumes BASE+SIZE fits in ADDR_W+1 bits; compares are done one bit wider
// so a window ending at the top of the address space works.
module apd_window #(
    parameter int unsigned          ADDR_W = 16,
    parameter logic [ADDR_W-1:0]    BASE   = '0,
    parameter int unsigned          SIZE   = 64
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [ADDR_W:0] LO = {1'b0, BASE};
    localparam logic [ADDR_W:0] HI = LO + (ADDR_W+1)'(SIZE);

    // Range compare of the widened address against both bounds.
    always_comb begin
        hit = ({1'b0, addr} >= LO) && ({1'b0, addr} < HI);
    end
endmodule

// File: rtl/apd_prio.sv
// Module: apd_prio
// Fixed-priority one-hot grant: request 0 wins over 1, 1 over 2, and so on.
// Assumes requests are already gated by strobe and enables.
module apd_prio #(
    parameter int unsigned N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    for (genvar g = 0; g < N; g++) begin : g_grant
        if (g == 0) begin : g_top
            // Highest priority needs no masking.
            always_comb grant[g] = req[g];
        end else begin : g_low
            // Lower entries are masked by any request above them.
            always_comb grant[g] = req[g] & ~(|req[g-1:0]);
        end
    end
endmodule

// File: rtl/apd_cfg_reg.sv
// Module: apd_cfg_reg
// Holds the configuration byte and gates its writes. In normal mode only
// the first write within WIN_CYCLES clocks after reset is stored; in
// special mode every write is stored. Reset is synchronous, active low.
module apd_cfg_reg #(
    parameter int unsigned        DATA_W     = 8,
    parameter int unsigned        WIN_CYCLES = 64,
    parameter logic [DATA_W-1:0]  CFG_RST    = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic              special_mode,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cfg_q
);
    localparam int unsigned CNT_W = $clog2(WIN_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WIN_CYCLES);

    logic [CNT_W-1:0] cyc_cnt;
    logic             wr_done;
    logic             win_open;
    logic             accept;

    // Decide whether the current write may update the register.
    always_comb begin
        win_open = (cyc_cnt < CNT_MAX);
        accept   = wr_hit && (special_mode || (win_open && !wr_done));
    end

    // Count bus cycles since reset, holding once the window has closed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cyc_cnt <= '0;
        else if (cyc_cnt != CNT_MAX)
            cyc_cnt <= cyc_cnt + 1'b1;
    end

    // Remember that the one normal-mode write has been used.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_done <= 1'b0;
        else if (accept && !special_mode)
            wr_done <= 1'b1;
    end

    // Store accepted write data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= CFG_RST;
        else if (accept)
            cfg_q <= wdata;
    end
endmodule

// File: rtl/addr_prio_decoder.sv
// Module: addr_prio_decoder (top)
// Decodes a CPU address into one-hot selects for register file, RAM and ROM
// with fixed priority where windows overlap, and hosts the timed
// configuration register at register base + 0x3F. Assumes one bus cycle per
// clock and strobes valid for the whole cycle. Reset is synchronous.
module addr_prio_decoder
    import apd_pkg::*;
#(
    parameter int unsigned          ADDR_W     = 16,
    parameter int unsigned          DATA_W     = 8,
    parameter logic [ADDR_W-1:0]    REG_BASE   = 16'h1000,
    parameter int unsigned          REG_SIZE   = 64,
    parameter logic [ADDR_W-1:0]    RAM_BASE   = 16'h0000,
    parameter int unsigned          RAM_SIZE   = 512,
    parameter logic [ADDR_W-1:0]    ROM_BASE   = 16'hD000,
    parameter int unsigned          ROM_SIZE   = 12288,
    parameter int unsigned          WIN_CYCLES = 64,
    parameter logic [DATA_W-1:0]    CFG_RST    = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              special_mode,
    output logic              sel_reg,
    output logic              sel_ram,
    output logic              sel_rom,
    output logic [DATA_W-1:0] cfg_bits,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] CFG_ADDR = REG_BASE + ADDR_W'(CFG_OFFSET);

    // Base address of resource i, indexed by priority.
    function automatic logic [ADDR_W-1:0] res_base(input int unsigned i);
        case (i)
            RES_REG: res_base = REG_BASE;
            RES_RAM: res_base = RAM_BASE;
            default: res_base = ROM_BASE;
        endcase
    endfunction

    // Window size of resource i, indexed by priority.
    function automatic int unsigned res_size(input int unsigned i);
        case (i)
            RES_REG: res_size = REG_SIZE;
            RES_RAM: res_size = RAM_SIZE;
            default: res_size = ROM_SIZE;
        endcase
    endfunction

    logic [NUM_RES-1:0] hit;
    logic [NUM_RES-1:0] req;
    logic [NUM_RES-1:0] grant;
    logic               strobe;
    logic               cfg_sel;
    logic [DATA_W-1:0]  cfg_q;

    for (genvar g = 0; g < NUM_RES; g++) begin : g_win
        apd_window #(
            .ADDR_W (ADDR_W),
            .BASE   (res_base(g)),
            .SIZE   (res_size(g))
        ) u_win (
            .addr (bus_addr),
            .hit  (hit[g])
        );
    end

    // Gate window hits by strobe and by the ROM enable bit.
    always_comb begin
        strobe       = bus_rd || bus_wr;
        req          = hit & {NUM_RES{strobe}};
        req[RES_ROM] = req[RES_ROM] & cfg_q[ROM_EN_BIT];
    end

    apd_prio #(.N(NUM_RES)) u_prio (
        .req   (req),
        .grant (grant)
    );

    // Config register is addressed only when the register file wins.
    always_comb cfg_sel = grant[RES_REG] && (bus_addr == CFG_ADDR);

    apd_cfg_reg #(
        .DATA_W     (DATA_W),
        .WIN_CYCLES (WIN_CYCLES),
        .CFG_RST    (CFG_RST)
    ) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_hit       (bus_wr && cfg_sel),
        .special_mode (special_mode),
        .wdata        (bus_wdata),
        .cfg_q        (cfg_q)
    );

    // Drive selects and the decoder's own read data.
    always_comb begin
        sel_reg  = grant[RES_REG];
        sel_ram  = grant[RES_RAM];
        sel_rom  = grant[RES_ROM];
        cfg_bits = cfg_q;
        if (!bus_rd)
            rd_data = '1;
        else if (cfg_sel)
            rd_data = cfg_q;
        else if (grant == '0)
            rd_data = '1;
        else
            rd_data = '0;
    end
endmodule

// File: rtl/apd_checker.sv
// Module: apd_checker
// Property checks for addr_prio_decoder, attached by bind below. Window
// membership is recomputed here from the parameters; the window-closed
// state uses a private cycle counter.
module apd_checker #(
    parameter int unsigned          ADDR_W     = 16,
    parameter int unsigned          DATA_W     = 8,
    parameter logic [ADDR_W-1:0]    REG_BASE   = 16'h1000,
    parameter int unsigned          REG_SIZE   = 64,
    parameter logic [ADDR_W-1:0]    RAM_BASE   = 16'h0000,
    parameter int unsigned          RAM_SIZE   = 512,
    parameter logic [ADDR_W-1:0]    ROM_BASE   = 16'hD000,
    parameter int unsigned          ROM_SIZE   = 12288,
    parameter int unsigned          WIN_CYCLES = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              special_mode,
    input logic              sel_reg,
    input logic              sel_ram,
    input logic              sel_rom,
    input logic [DATA_W-1:0] cfg_bits,
    input logic [DATA_W-1:0] rd_data
);
    localparam int unsigned CK_W = $clog2(WIN_CYCLES + 1);
    localparam logic [CK_W-1:0] CK_MAX = CK_W'(WIN_CYCLES);

    logic [ADDR_W:0] a_w;
    logic in_reg, in_ram, in_rom, strb, cfg_addr;
    logic [CK_W-1:0] ck_cnt;

    // Recompute window membership for the current address.
    always_comb begin
        a_w      = {1'b0, bus_addr};
        in_reg   = (a_w >= {1'b0, REG_BASE}) && (a_w < {1'b0, REG_BASE} + (ADDR_W+1)'(REG_SIZE));
        in_ram   = (a_w >= {1'b0, RAM_BASE}) && (a_w < {1'b0, RAM_BASE} + (ADDR_W+1)'(RAM_SIZE));
        in_rom   = (a_w >= {1'b0, ROM_BASE}) && (a_w < {1'b0, ROM_BASE} + (ADDR_W+1)'(ROM_SIZE));
        strb     = bus_rd || bus_wr;
        cfg_addr = (bus_addr == REG_BASE + ADDR_W'(63));
    end

    // Private count of cycles since reset, saturating at the window length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ck_cnt <= '0;
        else if (ck_cnt != CK_MAX)
            ck_cnt <= ck_cnt + 1'b1;
    end

    a_r3_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_reg, sel_ram, sel_rom}));

    a_r3_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !strb |-> !(sel_reg || sel_ram || sel_rom));

    a_r1_reg_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (strb && in_reg) |-> (sel_reg && !sel_ram && !sel_rom));

    a_r2_ram_over_rom: assert property (@(posedge clk) disable iff (!rst_n)
        (strb && in_ram && !in_reg) |-> (sel_ram && !sel_rom));

    a_r4_unmapped_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !in_reg && !in_ram && !in_rom) |-> (rd_data == '1 && !sel_ram && !sel_rom && !sel_reg));

    a_r5_rom_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_bits[1] |-> !sel_rom);

    a_r9_closed_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!special_mode && ck_cnt == CK_MAX) |=> $stable(cfg_bits));

    a_r10_special_store: assert property (@(posedge clk) disable iff (!rst_n)
        (special_mode && bus_wr && cfg_addr) |=> (cfg_bits == $past(bus_wdata)));
endmodule

bind addr_prio_decoder apd_checker #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .REG_BASE   (REG_BASE),
    .REG_SIZE   (REG_SIZE),
    .RAM_BASE   (RAM_BASE),
    .RAM_SIZE   (RAM_SIZE),
    .ROM_BASE   (ROM_BASE),
    .ROM_SIZE   (ROM_SIZE),
    .WIN_CYCLES (WIN_CYCLES)
) u_apd_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .special_mode (special_mode),
    .sel_reg      (sel_reg),
    .sel_ram      (sel_ram),
    .sel_rom      (sel_rom),
    .cfg_bits     (cfg_bits),
    .rd_data      (rd_data)
);

// File: tb/addr_prio_decoder_tb_top.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario. dut_i uses the default map;
// dut_ovl_i places RAM and ROM at 0xC000 and the register file at 0xC100.
module addr_prio_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        special_mode = 1'b0;

    logic       d_reg, d_ram, d_rom, o_reg, o_ram, o_rom;
    logic [7:0] d_cfg, d_rd, o_cfg, o_rd;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    addr_prio_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .special_mode(special_mode),
        .sel_reg(d_reg), .sel_ram(d_ram), .sel_rom(d_rom),
        .cfg_bits(d_cfg), .rd_data(d_rd)
    );

    addr_prio_decoder #(
        .REG_BASE(16'hC100), .RAM_BASE(16'hC000), .ROM_BASE(16'hC000)
    ) dut_ovl_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .special_mode(special_mode),
        .sel_reg(o_reg), .sel_ram(o_ram), .sel_rom(o_rom),
        .cfg_bits(o_cfg), .rd_data(o_rd)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic spec);
        @(negedge clk);
        special_mode = spec;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Read probe; selects encoded {rom,ram,reg}.
    task automatic probe(input bit ovl, input logic [15:0] a, input logic [2:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        bus_rd = 1'b1;
        #1;
        if (ovl) check(tag, {o_rom, o_ram, o_reg}, exp);
        else     check(tag, {d_rom, d_ram, d_reg}, exp);
        bus_rd = 1'b0;
    endtask

    // One write to the default config address, result checked next negedge.
    task automatic write_cfg(input logic [7:0] d, input logic [7:0] exp, input string tag);
        bus_addr = 16'h103F;
        bus_wdata = d;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check(tag, d_cfg, exp);
    endtask

    task automatic t_reset_state;
        do_reset(1'b0);
        check("R11 reset cfg", d_cfg, 8'h02);
        bus_addr = 16'h103F; bus_rd = 1'b1; #1;
        check("R6 read cfg", d_rd, 8'h02);
        bus_rd = 1'b0; #1;
        check("R3 no strobe no select", {d_rom, d_ram, d_reg}, 3'b000);
    endtask

    task automatic t_default_map;
        probe(0, 16'h0000, 3'b010, "R2 ram low");
        probe(0, 16'h01FF, 3'b010, "R2 ram top");
        probe(0, 16'h1000, 3'b001, "R1 reg low");
        probe(0, 16'h103F, 3'b001, "R1 reg top");
        probe(0, 16'hD000, 3'b100, "R5 rom low enabled");
        probe(0, 16'hFFFF, 3'b100, "R5 rom top enabled");
    endtask

    task automatic t_unmapped;
        probe(0, 16'h0200, 3'b000, "R4 gap above ram");
        probe(0, 16'h1040, 3'b000, "R4 gap above reg");
        probe(0, 16'hCFFF, 3'b000, "R4 gap below rom");
        @(negedge clk); bus_addr = 16'h0200; bus_rd = 1'b1; #1;
        check("R4 unmapped read ff", d_rd, 8'hFF);
        bus_addr = 16'h0000; #1;
        check("R4 mapped read not ff", d_rd, 8'h00);
        bus_rd = 1'b0;
    endtask

    task automatic t_overlap;
        probe(1, 16'hC000, 3'b010, "R2 ram over rom low");
        probe(1, 16'hC0FF, 3'b010, "R2 ram below reg");
        probe(1, 16'hC100, 3'b001, "R1 reg over ram+rom");
        probe(1, 16'hC13F, 3'b001, "R1 reg top overlap");
        probe(1, 16'hC140, 3'b010, "R2 ram above reg");
        probe(1, 16'hC1FF, 3'b010, "R2 ram top");
        probe(1, 16'hC200, 3'b100, "R2 rom past ram");
        probe(1, 16'hEFFF, 3'b100, "R2 rom top");
        probe(1, 16'hF000, 3'b000, "R4 above rom");
        @(negedge clk); bus_addr = 16'hC100; bus_wr = 1'b1; #1;
        check("R1 write uses reg", {o_rom, o_ram, o_reg}, 3'b001);
        bus_addr = 16'h1000;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic t_write_once;
        do_reset(1'b0);
        write_cfg(8'h0A, 8'h0A, "R7 first write at cycle 0");
        write_cfg(8'h55, 8'h0A, "R8 second write ignored");
        write_cfg(8'h02, 8'h0A, "R8 third write ignored");
    endtask

    task automatic t_rom_gate;
        do_reset(1'b0);
        write_cfg(8'h00, 8'h00, "R5 clear rom enable");
        probe(0, 16'hD000, 3'b000, "R5 rom disabled");
        @(negedge clk); bus_addr = 16'hE000; bus_rd = 1'b1; #1;
        check("R5 rom disabled reads ff", d_rd, 8'hFF);
        bus_rd = 1'b0;
        probe(0, 16'h0000, 3'b010, "R5 ram unaffected");
    endtask

    task automatic t_window_edge;
        do_reset(1'b0);
        repeat (63) @(negedge clk);
        write_cfg(8'h0B, 8'h0B, "R7 write at cycle 63");
        do_reset(1'b0);
        repeat (64) @(negedge clk);
        write_cfg(8'h0B, 8'h02, "R9 write at cycle 64");
        do_reset(1'b0);
        repeat (150) @(negedge clk);
        write_cfg(8'h0C, 8'h02, "R9 late write");
    endtask

    task automatic t_special;
        do_reset(1'b1);
        repeat (100) @(negedge clk);
        write_cfg(8'h11, 8'h11, "R10 late special write");
        write_cfg(8'h22, 8'h22, "R10 repeat special write");
        write_cfg(8'h06, 8'h06, "R10 third special write");
        special_mode = 1'b0;
        write_cfg(8'h33, 8'h06, "R9 normal after window");
        do_reset(1'b0);
        check("R11 reset after special", d_cfg, 8'h02);
    endtask

    initial begin
        t_reset_state();
        t_default_map();
        t_unmapped();
        t_overlap();
        t_write_once();
        t_rom_gate();
        t_window_edge();
        t_special();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule